// File: doc/BRIEF.md
# Serial Flash Read-Command Responder

This block is the device side of a serial flash memory, reduced to its two read commands. A host talks to it over a mode-0 SPI slave interface: chip select `cs_n`, serial clock `sck`, serial data in `si` and serial data out `so`. Because the block has no tri-state pad, the "driven" state of the output is carried by `so_en`. All three SPI inputs are brought into the `clk` domain through two-flop synchronizers. SCK edges are then found by comparing the synchronized level with its value one cycle earlier. This means SCK must stay high for at least 4 `clk` periods and low for at least 4 `clk` periods.

After `cs_n` falls, the block shifts in an 8-bit opcode and then a 24-bit address, MSB first. Opcode 03h starts a continuous read that runs across page ends and wraps around the whole array. Opcode D2h starts a page read: four filler bytes follow the address, and the byte pointer stays inside the addressed page. The `page256` input selects the page geometry. When it is 0, a page holds 264 bytes. When it is 1, a page holds 256 bytes and the address is a plain linear value.

The storage is a synchronous byte array that holds `NUM_PAGES` slots of 264 bytes. The slot for page p, byte b sits at linear location p*264+b in both geometries. The bench fills the array through a write port before any command is sent.

Top module: `flash_read_responder`

## Requirements
- R1: Opcode 03h, continuous read. The device drives the first data bit on the SCK falling edge that follows the 32nd header bit. The header is the opcode plus 24 address bits. There are no filler bits.
- R2: Opcode D2h, page read. 32 filler bits of any value follow the address. `so_en` stays 0 through all 64 header bits, and data starts on the falling edge after the 64th bit.
- R3: With `page264` geometry (`page256`=0), address bits 17..9 give the page and bits 8..0 give the byte offset. An offset of 264 or more has 264 subtracted from it.
- R4: With `page256`=1, address bits 16..8 give the page and bits 7..0 give the byte offset. In both geometries the page number is reduced modulo `NUM_PAGES`.
- R5: In a continuous read, the byte after the last offset of a page (255 or 263) is offset 0 of the next page, with no gap in the bit stream.
- R6: In a continuous read, the byte after the last byte of page `NUM_PAGES`-1 is page 0, offset 0, with no gap.
- R7: In a page read, the byte after the last offset of the page is offset 0 of the same page.
- R8: Data leaves MSB first. `so` and `so_en` change only after SCK falling edges, so each bit is valid at the next SCK rising edge. While `so_en` is 1, `so` holds its value between falling edges.
- R9: When `cs_n` rises, the command ends at once, whatever phase it is in. `so_en` returns to 0 within 3 `clk` cycles, and the next command after `cs_n` falls again is decoded from scratch.
- R10: Any opcode other than 03h or D2h keeps `so_en` at 0 until `cs_n` rises, however many SCK edges follow.
- R11: Address bits 23..18 are ignored in both geometries. Bit 17 is also ignored with `page256`=1.
- R12: After reset, `so_en` and `so` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all logic samples on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| page256 | input | 1 | Page geometry: 0 = 264-byte pages, 1 = 256-byte pages; change only while `cs_n` is high |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 (idles low) |
| si | input | 1 | SPI serial data in, sampled on SCK rising edges |
| so | output | 1 | SPI serial data out, MSB first; 0 when not driven |
| so_en | output | 1 | 1 while `so` is driven; 0 means the pin is released |
| load_we | input | 1 | Array preload write strobe |
| load_addr | input | MEM_AW | Array preload location (page*264 + byte) |
| load_data | input | 8 | Array preload byte |

## Verification
The header counter, the address registers and the byte pointer are all visible through the byte stream on `so`. If the counter is off by one bit, every data byte comes out shifted by one position from its first bit onward. A wrong page or offset decode gives a wrong first byte, seen 8 SCK cycles after the header ends. A stepping fault at a page or array end shows only in the one byte just past that boundary, so the bench starts reads a few bytes before each boundary and checks every byte across it. A state machine that stays stuck after `cs_n` rises shows `so_en` still high a few `clk` cycles later, or gives a corrupted first byte in the next command.

// File: rtl/frr_pkg.sv
package frr_pkg;

    localparam logic [7:0] OP_CONT_READ = 8'h03;
    localparam logic [7:0] OP_PAGE_READ = 8'hD2;

    localparam int OPC_BITS  = 8;
    localparam int ADDR_BITS = 24;
    localparam int FILL_BITS = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_FILL,
        ST_DATA,
        ST_IGNORE
    } frr_state_e;

endpackage

// File: rtl/frr_sync.sv
module frr_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/frr_step.sv
module frr_step #(
    parameter int PG_W      = 3,
    parameter int OFF_W     = 9,
    parameter int PAGE_LONG = 264
) (
    input  logic [PG_W-1:0]  page,
    input  logic [OFF_W-1:0] off,
    input  logic             page256,
    input  logic             stay_in_page,
    output logic [PG_W-1:0]  nxt_page,
    output logic [OFF_W-1:0] nxt_off
);
    logic [OFF_W-1:0] last_off;

    always_comb begin
        last_off = page256 ? OFF_W'(255) : OFF_W'(PAGE_LONG - 1);
        if (off == last_off) begin
            nxt_off  = '0;
            nxt_page = stay_in_page ? page : page + PG_W'(1);
        end else begin
            nxt_off  = off + OFF_W'(1);
            nxt_page = page;
        end
    end
endmodule

// File: rtl/frr_mem.sv
module frr_mem #(
    parameter int DEPTH = 2112,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) begin
            cells[waddr] <= wdata;
        end
        rdata <= cells[raddr];
    end
endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
    import frr_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int PAGE_LONG = 264,
    localparam int PG_W      = $clog2(NUM_PAGES),
    localparam int OFF_W     = $clog2(PAGE_LONG),
    localparam int MEM_DEPTH = NUM_PAGES * PAGE_LONG,
    localparam int MEM_AW    = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page256,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    output logic              so,
    output logic              so_en,
    input  logic              load_we,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [7:0]        load_data
);
    localparam int CNT_W = 6;

    typedef struct packed {
        frr_state_e       state;
        logic [CNT_W-1:0] bitcnt;
        logic [23:0]      shreg;
        logic             is_cont;
        logic [PG_W-1:0]  page;
        logic [OFF_W-1:0] off;
        logic [2:0]       obit;
        logic [7:0]       oshift;
        logic             so;
        logic             so_en;
        logic             sck_prev;
    } frr_regs_t;

    localparam frr_regs_t REGS_RST = '{
        state:    ST_IDLE,
        bitcnt:   '0,
        shreg:    '0,
        is_cont:  1'b0,
        page:     '0,
        off:      '0,
        obit:     '0,
        oshift:   '0,
        so:       1'b0,
        so_en:    1'b0,
        sck_prev: 1'b0
    };

    frr_regs_t q, d;

    // synchronized SPI inputs: {cs, sck, si}
    logic [2:0] spi_s;
    logic       cs_s, sck_s, si_s;
    logic       sck_rise, sck_fall;

    frr_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sck, si}),
        .sync_out (spi_s)
    );

    assign cs_s     = spi_s[2];
    assign sck_s    = spi_s[1];
    assign si_s     = spi_s[0];
    assign sck_rise = sck_s & ~q.sck_prev;
    assign sck_fall = ~sck_s & q.sck_prev;

    // address decode of the freshly completed shift word
    logic [23:0]      sh_new;
    logic [8:0]       pg_raw;
    logic [OFF_W-1:0] off_raw;
    logic [OFF_W-1:0] off_dec;
    logic [PG_W-1:0]  pg_dec;
    logic             unused_bits;

    always_comb begin
        sh_new  = {q.shreg[22:0], si_s};
        pg_raw  = page256 ? sh_new[16:8] : sh_new[17:9];
        off_raw = page256 ? OFF_W'(sh_new[7:0]) : OFF_W'(sh_new[8:0]);
        if (!page256 && (off_raw >= OFF_W'(PAGE_LONG))) begin
            off_dec = off_raw - OFF_W'(PAGE_LONG);
        end else begin
            off_dec = off_raw;
        end
        pg_dec = pg_raw[PG_W-1:0];
    end

    assign unused_bits = ^{sh_new[23:18], pg_raw[8:PG_W]};

    // pointer stepping
    logic [PG_W-1:0]  step_page;
    logic [OFF_W-1:0] step_off;

    frr_step #(.PG_W(PG_W), .OFF_W(OFF_W), .PAGE_LONG(PAGE_LONG)) u_step (
        .page         (q.page),
        .off          (q.off),
        .page256      (page256),
        .stay_in_page (~q.is_cont),
        .nxt_page     (step_page),
        .nxt_off      (step_off)
    );

    // array
    logic [MEM_AW-1:0] rd_addr;
    logic [7:0]        rd_data;

    assign rd_addr = MEM_AW'(q.page) * MEM_AW'(PAGE_LONG) + MEM_AW'(q.off);

    frr_mem #(.DEPTH(MEM_DEPTH), .AW(MEM_AW)) u_mem (
        .clk   (clk),
        .we    (load_we),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // next-state logic
    always_comb begin
        d          = q;
        d.sck_prev = sck_s;
        if (cs_s) begin
            d.state  = ST_IDLE;
            d.bitcnt = '0;
            d.so     = 1'b0;
            d.so_en  = 1'b0;
        end else begin
            unique case (q.state)
                ST_IDLE: begin
                    d.state  = ST_OPCODE;
                    d.bitcnt = '0;
                end
                ST_OPCODE: begin
                    if (sck_rise) begin
                        d.shreg  = sh_new;
                        d.bitcnt = q.bitcnt + CNT_W'(1);
                        if (q.bitcnt == CNT_W'(OPC_BITS - 1)) begin
                            d.bitcnt = '0;
                            if (sh_new[7:0] == OP_CONT_READ) begin
                                d.state   = ST_ADDR;
                                d.is_cont = 1'b1;
                            end else if (sh_new[7:0] == OP_PAGE_READ) begin
                                d.state   = ST_ADDR;
                                d.is_cont = 1'b0;
                            end else begin
                                d.state = ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ADDR: begin
                    if (sck_rise) begin
                        d.shreg  = sh_new;
                        d.bitcnt = q.bitcnt + CNT_W'(1);
                        if (q.bitcnt == CNT_W'(ADDR_BITS - 1)) begin
                            d.bitcnt = '0;
                            d.page   = pg_dec;
                            d.off    = off_dec;
                            d.obit   = '0;
                            d.state  = q.is_cont ? ST_DATA : ST_FILL;
                        end
                    end
                end
                ST_FILL: begin
                    if (sck_rise) begin
                        d.bitcnt = q.bitcnt + CNT_W'(1);
                        if (q.bitcnt == CNT_W'(FILL_BITS - 1)) begin
                            d.bitcnt = '0;
                            d.state  = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (sck_fall) begin
                        d.so_en = 1'b1;
                        d.obit  = q.obit + 3'd1;
                        if (q.obit == 3'd0) begin
                            d.so     = rd_data[7];
                            d.oshift = {rd_data[6:0], 1'b0};
                            d.page   = step_page;
                            d.off    = step_off;
                        end else begin
                            d.so     = q.oshift[7];
                            d.oshift = {q.oshift[6:0], 1'b0};
                        end
                    end
                end
                ST_IGNORE: begin
                    d.so_en = 1'b0;
                end
                default: d = REGS_RST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    assign so    = q.so;
    assign so_en = q.so_en;

    // observation points for the bound checker
    logic             chk_in_header;
    logic             chk_in_ignore;
    logic             chk_in_data;
    logic [OFF_W-1:0] chk_off;

    assign chk_in_header = (q.state == ST_OPCODE) || (q.state == ST_ADDR) || (q.state == ST_FILL);
    assign chk_in_ignore = (q.state == ST_IGNORE);
    assign chk_in_data   = (q.state == ST_DATA);
    assign chk_off       = q.off;
endmodule

// File: rtl/frr_chk.sv
module frr_chk #(
    parameter int OFF_W     = 9,
    parameter int PAGE_LONG = 264
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_sync,
    input logic             sck_fall,
    input logic             so,
    input logic             so_en,
    input logic             page256,
    input logic             in_header,
    input logic             in_ignore,
    input logic             in_data,
    input logic [OFF_W-1:0] off
);
    // R9: a deselected device releases its output on the next cycle
    assert_release_on_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_sync |=> !so_en);

    // R8: the driven bit only moves after a falling SCK edge
    assert_so_moves_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (so_en && !sck_fall && !cs_sync) |=> $stable(so));

    // R8: driving begins on a falling SCK edge
    assert_drive_starts_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(so_en) |-> $past(sck_fall));

    // R10: an unknown opcode never drives the output
    assert_unknown_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ignore |-> !so_en);

    // R2: nothing is driven during opcode, address or filler
    assert_header_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_header |-> !so_en);

    // R3: the byte pointer always stays inside the selected page size
    assert_offset_in_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_data |-> ({1'b0, off} < (page256 ? (OFF_W+1)'(256) : (OFF_W+1)'(PAGE_LONG))));
endmodule

bind flash_read_responder frr_chk #(.OFF_W(OFF_W), .PAGE_LONG(PAGE_LONG)) u_frr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_sync   (cs_s),
    .sck_fall  (sck_fall),
    .so        (so),
    .so_en     (so_en),
    .page256   (page256),
    .in_header (chk_in_header),
    .in_ignore (chk_in_ignore),
    .in_data   (chk_in_data),
    .off       (chk_off)
);

// File: tb/flash_read_responder_bench.sv
module flash_read_responder_bench;
    localparam int NP    = 8;
    localparam int PL    = 264;
    localparam int DEPTH = NP * PL;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          page256 = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic          si = 1'b0;
    logic          so, so_en;
    logic          load_we = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [7:0]    load_data = '0;

    flash_read_responder #(.NUM_PAGES(NP), .PAGE_LONG(PL)) u_flash_read_responder (
        .clk       (clk),
        .rst_n     (rst_n),
        .page256   (page256),
        .cs_n      (cs_n),
        .sck       (sck),
        .si        (si),
        .so        (so),
        .so_en     (so_en),
        .load_we   (load_we),
        .load_addr (load_addr),
        .load_data (load_data)
    );

    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;
    string      cur_req = "R12";
    logic [7:0] exp_q[$];
    bit         cap = 1'b0;
    bit         hdr_chk = 1'b0;
    bit         hdr_bad = 1'b0;
    bit         en_bad = 1'b0;
    int         mcnt = 0;
    logic [7:0] mbyte = '0;
    logic [7:0] eb;

    function automatic logic [7:0] img(int idx);
        return 8'((idx * 37) + ((idx >> 5) * 11) + 3);
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: the host samples on rising SCK
    always @(posedge sck) begin
        if (cap) begin
            if (!so_en) en_bad = 1'b1;
            mbyte = {mbyte[6:0], so};
            mcnt++;
            if (mcnt == 8) begin
                mcnt = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, int'(mbyte), 0);
                end else begin
                    eb = exp_q.pop_front();
                    chk((mbyte == eb) && !en_bad, cur_req, int'(mbyte), int'(eb));
                end
                en_bad = 1'b0;
            end
        end
    end

    // driver-side model: pushes the bytes a correct device must return
    task automatic expect_bytes(bit m256, logic [7:0] op, logic [23:0] a, int n);
        int pg, of, last;
        if (m256) begin
            pg = int'(a[16:8]);
            of = int'(a[7:0]);
        end else begin
            pg = int'(a[17:9]);
            of = int'(a[8:0]);
            if (of >= PL) of -= PL;
        end
        pg   = pg % NP;
        last = m256 ? 255 : PL - 1;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(img(pg * PL + of));
            if (of == last) begin
                of = 0;
                if (op == 8'h03) pg = (pg + 1) % NP;
            end else begin
                of++;
            end
        end
    endtask

    task automatic send_bit(logic b);
        si = b;
        repeat (5) @(negedge clk);
        if (hdr_chk && so_en) hdr_bad = 1'b1;
        sck = 1'b1;
        repeat (5) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic send_bits(logic [31:0] v, int nb);
        for (int i = nb - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic sel;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic desel;
        @(negedge clk);
        sck  = 1'b0;
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_read(bit m256, logic [7:0] op, logic [23:0] a, int n, string req);
        page256 = m256;
        cur_req = req;
        expect_bytes(m256, op, a, n);
        sel();
        hdr_bad = 1'b0;
        hdr_chk = 1'b1;
        send_bits({24'd0, op}, 8);
        send_bits({8'd0, a}, 24);
        if (op == 8'hD2) send_bits(32'hA55A_C33C, 32);
        hdr_chk = 1'b0;
        chk(!hdr_bad, {req, " R2 header quiet"}, int'(hdr_bad), 0);
        cap = 1'b1;
        repeat (n * 8) send_bit(1'b0);
        cap = 1'b0;
        desel();
        chk(exp_q.size() == 0, {req, " bytes left"}, exp_q.size(), 0);
        exp_q.delete();
        mcnt = 0;
    endtask

    function automatic logic [23:0] a264(int pg, int of);
        return 24'((pg << 9) | of);
    endfunction

    function automatic logic [23:0] a256(int pg, int of);
        return 24'((pg << 8) | of);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(so_en == 1'b0, "R12 so_en", int'(so_en), 0);
        chk(so == 1'b0, "R12 so", int'(so), 0);

        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            load_we   = 1'b1;
            load_addr = AW'(i);
            load_data = img(i);
        end
        @(negedge clk);
        load_we = 1'b0;
        repeat (4) @(negedge clk);

        // R1 / R3 / R8: plain continuous read, 264-byte geometry
        do_read(1'b0, 8'h03, a264(2, 5), 4, "R1 R3 R8");
        // R5: continuous read across a 264-byte page end
        do_read(1'b0, 8'h03, a264(1, 261), 6, "R5 page264");
        // R6: continuous read off the last page wraps to page 0
        do_read(1'b0, 8'h03, a264(7, 262), 4, "R6 page264");
        // R2 / R7: page read wraps inside the page
        do_read(1'b0, 8'hD2, a264(3, 260), 6, "R2 R7 page264");
        // R3: offset 300 folds to 36
        do_read(1'b0, 8'h03, a264(2, 300), 3, "R3 offset fold");
        // R4 / R5: 256-byte geometry crossing a page end
        do_read(1'b1, 8'h03, a256(5, 254), 4, "R4 R5 page256");
        // R6: 256-byte geometry wrap of the whole array
        do_read(1'b1, 8'h03, a256(7, 255), 3, "R6 page256");
        // R7: 256-byte geometry page read wrap
        do_read(1'b1, 8'hD2, a256(2, 250), 10, "R7 page256");
        // R11: upper address bits set
        do_read(1'b0, 8'h03, 24'hFC0000 | a264(4, 10), 3, "R11 page264");
        do_read(1'b1, 8'h03, 24'h020000 | a256(3, 7), 3, "R11 page256");
        // R4: page number beyond the array folds modulo NUM_PAGES
        do_read(1'b0, 8'h03, a264(13, 20), 2, "R4 page fold");

        // R10: unknown opcode keeps SO released
        page256 = 1'b0;
        sel();
        hdr_bad = 1'b0;
        hdr_chk = 1'b1;
        send_bits(32'h5A, 8);
        send_bits(32'hFFFF_FFFF, 32);
        send_bits(32'h0000_00FF, 16);
        repeat (5) @(negedge clk);
        if (so_en) hdr_bad = 1'b1;
        hdr_chk = 1'b0;
        chk(!hdr_bad, "R10 unknown opcode", int'(hdr_bad), 0);
        desel();

        // R9: abort in the middle of a data byte
        cur_req = "R9 abort data";
        expect_bytes(1'b0, 8'h03, a264(6, 100), 1);
        sel();
        send_bits(32'h03, 8);
        send_bits({8'd0, a264(6, 100)}, 24);
        cap = 1'b1;
        repeat (8) send_bit(1'b0);
        cap = 1'b0;
        repeat (3) send_bit(1'b0);
        chk(so_en == 1'b1, "R9 driving before abort", int'(so_en), 1);
        @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(so_en == 1'b0, "R9 released after abort", int'(so_en), 0);
        chk(so == 1'b0, "R9 so low after abort", int'(so), 0);
        repeat (5) @(negedge clk);
        exp_q.delete();

        // R9: abort in the address phase, then a fresh command
        sel();
        send_bits(32'h03, 8);
        send_bits(32'hABC, 12);
        desel();
        do_read(1'b0, 8'hD2, a264(5, 262), 4, "R9 after abort");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule